// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address of each beat of a four-beat burst. A load strobe captures a starting address; every later advance strobe moves to the next beat. Only the two least significant address bits take part in the burst. The bits above them stay at the loaded value until the next load.

A static mode input selects the beat order. In interleaved order, the low bits are the start bits XORed with the beat count. In linear order, they are the start bits plus the beat count, modulo four. After four advances the sequence returns to the starting address.

A clock enable freezes the whole block when it is low. The block is meant to sit beside a burst memory controller, which owns command decoding and the memory array.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `cur_addr` is all zeros and `beat` is 0.
- R2: A load (`clk_en`=1, `load`=1) makes `beat` 0 and `cur_addr` equal to `start_addr` on the next cycle.
- R3: When `interleave` is 1, `cur_addr[1:0]` equals the loaded start bits XOR `beat`. From a start of 01 the beats read 01, 00, 11, 10.
- R4: When `interleave` is 0, `cur_addr[1:0]` equals the loaded start bits plus `beat`, modulo 4. From a start of 01 the beats read 01, 10, 11, 00.
- R5: Each advance (`clk_en`=1, `load`=0, `advance`=1) raises `beat` by one, modulo 4. The fourth advance after a load brings `cur_addr` back to the loaded address.
- R6: While `clk_en` is 0, `beat` and `cur_addr` hold their values, even if `load` or `advance` is high.
- R7: `cur_addr[ADDR_W-1:2]` keeps the loaded upper bits for every cycle up to the next load.
- R8: When `load` and `advance` are both high, the load wins and `beat` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; low freezes all state |
| load | input | 1 | Capture `start_addr` and clear the beat count |
| start_addr | input | ADDR_W | Starting address of the burst |
| advance | input | 1 | Step to the next beat |
| interleave | input | 1 | Beat order: 1 selects XOR order, 0 selects modulo-4 add order |
| cur_addr | output | ADDR_W | Address of the current beat |
| beat | output | 2 | Beat index since the last load |

## Verification
All four start values are run through a full burst in both orders, and each beat is compared with a table and with the XOR or add formula. Starts 00 and 10 give the same sequence in both orders, so they test the wrap without telling the orders apart. Starts 01 and 11 produce different sequences in the two orders, so they catch a swapped or wrong order.

Each vector also uses a different upper-bit pattern, which shows whether a carry from the low bits leaks upward. Directed cases cover a stalled clock enable with load and advance high, and a load together with an advance.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              advance,
  input  logic              interleave,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        beat
);
  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [1:0]        low_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= 2'd0;
    end else if (clk_en) begin
      if (load) begin
        base_q <= start_addr;
        beat_q <= 2'd0;
      end else if (advance) begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  assign low_bits = interleave ? (base_q[1:0] ^ beat_q) : (base_q[1:0] + beat_q);
  assign cur_addr = {base_q[ADDR_W-1 -: HI_W], low_bits};
  assign beat     = beat_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              load,
  input logic [ADDR_W-1:0] start_addr,
  input logic              advance,
  input logic              interleave,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [1:0]        beat
);
  logic [1:0] seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              seed <= 2'd0;
    else if (clk_en && load) seed <= start_addr[1:0];
  end

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> (beat == 2'd0 && cur_addr == '0));

  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && load) |=> (beat == 2'd0 && cur_addr == $past(start_addr)));

  a_r3_xor_order: assert property (@(posedge clk) disable iff (!rst_n)
    interleave |-> (cur_addr[1:0] == (seed ^ beat)));

  a_r4_add_order: assert property (@(posedge clk) disable iff (!rst_n)
    !interleave |-> (cur_addr[1:0] == 2'(seed + beat)));

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !load && advance) |=> (beat == 2'($past(beat) + 2'd1)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(beat) && $stable(cur_addr[ADDR_W-1:2])));

  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_en && load) |=> $stable(cur_addr[ADDR_W-1:2]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .load(load),
  .start_addr(start_addr), .advance(advance), .interleave(interleave),
  .cur_addr(cur_addr), .beat(beat)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int ADDR_W = 18;

  // {mode, start[1:0], beat0, beat1, beat2, beat3}
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b1, 2'd1, 2'd1, 2'd0, 2'd3, 2'd2},
    {1'b1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b1, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0},
    {1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0},
    {1'b0, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b0, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clk_en = 1'b0;
  logic              load = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              advance = 1'b0;
  logic              interleave = 1'b1;
  logic [ADDR_W-1:0] cur_addr;
  logic [1:0]        beat;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .load(load),
    .start_addr(start_addr), .advance(advance), .interleave(interleave),
    .cur_addr(cur_addr), .beat(beat)
  );

  task automatic check(input string req, input logic [ADDR_W-1:0] act_a,
                       input logic [ADDR_W-1:0] exp_a, input logic [1:0] act_b,
                       input logic [1:0] exp_b);
    n_chk++;
    if (act_a !== exp_a || act_b !== exp_b) begin
      n_fail++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, act_a, act_b, exp_a, exp_b);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] base;
    logic [1:0]        s, ref_lo;
    @(negedge clk);
    check("R1 reset", cur_addr, '0, beat, 2'd0);
    step();
    rst_n = 1'b1;
    clk_en = 1'b1;
    step();
    check("R1 after release", cur_addr, '0, beat, 2'd0);

    for (int i = 0; i < 8; i++) begin
      s = VEC[i][9:8];
      base = {16'hA5C3 ^ 16'(i * 16'h1111), s};
      interleave = VEC[i][10];
      start_addr = base;
      load = 1'b1;
      step();
      load = 1'b0;
      check("R2 load", cur_addr, base, beat, 2'd0);
      advance = 1'b1;
      for (int k = 0; k < 4; k++) begin
        logic [1:0] exp_lo;
        exp_lo = VEC[i][7 - 2*k -: 2];
        ref_lo = VEC[i][10] ? (s ^ 2'(k)) : 2'(s + 2'(k));
        check(VEC[i][10] ? "R3 xor table" : "R4 add table",
              cur_addr, {base[ADDR_W-1:2], exp_lo}, beat, 2'(k));
        check(VEC[i][10] ? "R3 xor formula" : "R4 add formula",
              cur_addr, {base[ADDR_W-1:2], ref_lo}, beat, 2'(k));
        step();
      end
      advance = 1'b0;
      check("R5 R7 wrap to start", cur_addr, base, beat, 2'd0);
    end

    // R6: stall with load and advance requested
    interleave = 1'b0;
    start_addr = {16'h1234, 2'd2};
    load = 1'b1;
    step();
    load = 1'b0;
    advance = 1'b1;
    step();
    check("R5 one advance", cur_addr, {16'h1234, 2'd3}, beat, 2'd1);
    clk_en = 1'b0;
    load = 1'b1;
    start_addr = {16'hFFFF, 2'd0};
    step();
    step();
    check("R6 stall holds", cur_addr, {16'h1234, 2'd3}, beat, 2'd1);
    load = 1'b0;
    step();
    check("R6 stall advance ignored", cur_addr, {16'h1234, 2'd3}, beat, 2'd1);
    clk_en = 1'b1;
    step();
    check("R5 R7 resume", cur_addr, {16'h1234, 2'd0}, beat, 2'd2);

    // R8: load and advance together
    load = 1'b1;
    advance = 1'b1;
    start_addr = {16'h0F0F, 2'd1};
    step();
    load = 1'b0;
    advance = 1'b0;
    check("R8 load priority", cur_addr, {16'h0F0F, 2'd1}, beat, 2'd0);
    interleave = 1'b1;
    advance = 1'b1;
    step();
    advance = 1'b0;
    check("R3 xor after mode switch", cur_addr, {16'h0F0F, 2'd0}, beat, 2'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule